// File: doc/BRIEF.md
# Sectored Write-Back Data Cache

This block is a small direct-mapped data cache. Each line has one address tag and is divided into sectors. Every sector keeps its own valid flag and its own dirty flag. A store writes only the sector it addresses and never fetches the rest of the line. A load that finds its tag but an empty sector fetches just that one sector. When a request maps to a line that holds a different tag, the old line is evicted. Only the sectors marked dirty go back to memory, one at a time, from the lowest sector index to the highest.

Addresses are word addresses, and one word is one sector. The lowest `log2(SECTORS)` bits select the sector. The next `log2(LINES)` bits select the line, and the remaining upper bits form the tag. The CPU side is a valid/ready request channel. A request that cannot complete yet sees `req_ready` low, and it must stay on the port unchanged until it is accepted. Load data comes back on a one-cycle response pulse, and that response has no back-pressure.

The memory side is a valid/ready request channel for single-sector reads and writes. A read's data returns later as a one-cycle `mem_rsp_valid` pulse.

Top module: `sector_cache`

## Requirements
- R1: After reset every sector of every line is invalid and clean, and every tag is zero. The first load to any address therefore issues a memory read, and no eviction produces a memory write.
- R2: A store whose tag matches the line is accepted in the same cycle it is presented (`req_ready` high). It writes its sector, marks that sector valid and dirty, and causes no memory traffic.
- R3: A store never fetches other sectors. After a store to a line, a load of the stored sector returns the stored word with no memory access. A load of a sector left invalid reads exactly that one sector address from memory.
- R4: A load hits when the tag matches and the addressed sector is valid. It is accepted in the cycle it is presented, and `rsp_valid` is high with the word on `rsp_rdata` in the following cycle. Stores never raise `rsp_valid`.
- R5: A load to an invalid sector under a matching tag issues one memory read at the load's own address. The returned word fills that sector as valid and clean, and the load then completes as a hit.
- R6: On a tag mismatch, each dirty sector of the resident line is written to memory at address {old tag, line, sector}, in ascending sector order. Clean sectors are not written. After that the line's flags are cleared and the new tag is installed.
- R7: `req_ready` stays low for a request until every write-back and fill it needs has completed. The requester holds `req_valid`, `req_addr`, `req_write` and `req_wdata` steady while it waits.
- R8: A memory request holds `mem_req_valid`, `mem_req_addr`, `mem_req_write` and `mem_req_wdata` steady until `mem_req_ready` is seen. A read finishes when `mem_rsp_valid` delivers its word.
- R9: Stores are written back, not written through. Repeated stores to one sector merge in the cache, and memory receives only the last value, and only when the line is evicted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | CPU request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = sector write-back, 0 = sector read |
| mem_req_addr | output | ADDR_W | Word address of the memory sector |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_rdata | input | DATA_W | Memory read data |

## Verification
The hardest case to reach is an eviction of a line that is only partly dirty, with its dirty sectors scattered, that happens while the memory stalls its ready signal. The stimulus sets this up directly. It stores to two middle sectors and fills the two outer sectors clean, then loads an address with a different tag on the same line. The memory model withholds `mem_req_ready` in a repeating pattern. A long pseudo-random run follows on four tags and four lines, so that evictions, refills and merged stores overlap. A behavioural model of tags, flags and a memory image predicts every memory transfer and every load value.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WBACK     = 2'd1,
    ST_FILL_REQ  = 2'd2,
    ST_FILL_WAIT = 2'd3
  } sc_state_e;
endpackage

// File: rtl/sc_meta.sv
module sc_meta #(
  parameter int LINES   = 16,
  parameter int SECTORS = 4,
  parameter int TAG_W   = 6,
  parameter int IDX_W   = $clog2(LINES),
  parameter int SEC_W   = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   idx,
  input  logic               set_en,
  input  logic [SEC_W-1:0]   set_sec,
  input  logic               set_dirty,
  input  logic               clr_en,
  input  logic [SEC_W-1:0]   clr_sec,
  input  logic               inst_en,
  input  logic [TAG_W-1:0]   inst_tag,
  output logic [TAG_W-1:0]   line_tag,
  output logic [SECTORS-1:0] line_valid,
  output logic [SECTORS-1:0] line_dirty
);
  logic [TAG_W-1:0]   tag_q [LINES];
  logic [SECTORS-1:0] val_q [LINES];
  logic [SECTORS-1:0] drt_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        val_q[i] <= '0;
        drt_q[i] <= '0;
      end
    end else if (inst_en) begin
      tag_q[idx] <= inst_tag;
      val_q[idx] <= '0;
      drt_q[idx] <= '0;
    end else begin
      if (set_en) begin
        val_q[idx][set_sec] <= 1'b1;
        drt_q[idx][set_sec] <= set_dirty;
      end
      if (clr_en) drt_q[idx][clr_sec] <= 1'b0;
    end
  end

  assign line_tag   = tag_q[idx];
  assign line_valid = val_q[idx];
  assign line_dirty = drt_q[idx];
endmodule

// File: rtl/sc_data.sv
module sc_data #(
  parameter int LINES   = 16,
  parameter int SECTORS = 4,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = $clog2(LINES),
  parameter int SEC_W   = $clog2(SECTORS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SEC_W-1:0]  wr_sec,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEC_W-1:0]  rd_sec,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WORDS = LINES * SECTORS;
  logic [DATA_W-1:0] word_q [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[{idx, wr_sec}] <= wr_data;
  end

  assign rd_data = word_q[{idx, rd_sec}];
endmodule

// File: rtl/sc_first_set.sv
module sc_first_set #(
  parameter int N = 4,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] pos
);
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        pos   = W'(i);
      end
    end
  end
endmodule

// File: rtl/sector_cache.sv
module sector_cache
  import sc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int SECTORS = 4,
  parameter int LINES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  localparam int SEC_W = $clog2(SECTORS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - SEC_W - IDX_W;

  sc_state_e state_q, state_d;

  logic [SEC_W-1:0]   sec;
  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   req_tag;
  logic [TAG_W-1:0]   line_tag;
  logic [SECTORS-1:0] line_valid, line_dirty;
  logic               tag_hit, any_dirty;
  logic [SEC_W-1:0]   wb_sec;
  logic               set_en, set_dirty, clr_en, inst_en;
  logic               dat_we;
  logic [DATA_W-1:0]  dat_wdata, dat_rdata;
  logic [SEC_W-1:0]   dat_rsec;

  assign sec     = req_addr[SEC_W-1:0];
  assign idx     = req_addr[SEC_W +: IDX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign tag_hit = (line_tag == req_tag);

  sc_meta #(.LINES(LINES), .SECTORS(SECTORS), .TAG_W(TAG_W)) u_meta (
    .clk(clk), .rst_n(rst_n), .idx(idx),
    .set_en(set_en), .set_sec(sec), .set_dirty(set_dirty),
    .clr_en(clr_en), .clr_sec(wb_sec),
    .inst_en(inst_en), .inst_tag(req_tag),
    .line_tag(line_tag), .line_valid(line_valid), .line_dirty(line_dirty)
  );

  sc_first_set #(.N(SECTORS)) u_pick (
    .vec(line_dirty), .found(any_dirty), .pos(wb_sec)
  );

  assign dat_rsec  = (state_q == ST_WBACK) ? wb_sec : sec;
  assign dat_wdata = (state_q == ST_FILL_WAIT) ? mem_rsp_rdata : req_wdata;

  sc_data #(.LINES(LINES), .SECTORS(SECTORS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .wr_en(dat_we), .idx(idx), .wr_sec(sec), .wr_data(dat_wdata),
    .rd_sec(dat_rsec), .rd_data(dat_rdata)
  );

  assign mem_req_wdata = dat_rdata;

  always_comb begin
    state_d       = state_q;
    req_ready     = 1'b0;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = req_addr;
    set_en        = 1'b0;
    set_dirty     = 1'b0;
    clr_en        = 1'b0;
    inst_en       = 1'b0;
    dat_we        = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!tag_hit) begin
            state_d = ST_WBACK;
          end else if (req_write) begin
            req_ready = 1'b1;
            dat_we    = 1'b1;
            set_en    = 1'b1;
            set_dirty = 1'b1;
          end else if (line_valid[sec]) begin
            req_ready = 1'b1;
          end else begin
            state_d = ST_FILL_REQ;
          end
        end
      end
      ST_WBACK: begin
        if (any_dirty) begin
          mem_req_valid = 1'b1;
          mem_req_write = 1'b1;
          mem_req_addr  = {line_tag, idx, wb_sec};
          clr_en        = mem_req_ready;
        end else begin
          inst_en = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_FILL_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (mem_rsp_valid) begin
          dat_we  = 1'b1;
          set_en  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= req_valid && req_ready && !req_write;
      if (req_valid && req_ready && !req_write) rsp_rdata <= dat_rdata;
    end
  end

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write)));

  // R6
  wb_dirty_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |->
      (line_dirty[mem_req_addr[SEC_W-1:0]] && (line_tag != req_tag)));

  // R6
  wb_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=>
      (!(mem_req_valid && mem_req_write) ||
       (mem_req_addr[SEC_W-1:0] > $past(mem_req_addr[SEC_W-1:0]))));

  // R5
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL_WAIT && mem_rsp_valid) |=> (line_valid[sec] && !line_dirty[sec]));
endmodule

// File: tb/sector_cache_test.sv
module sector_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;

  sector_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    return 32'hC0DE_0000 ^ (32'(a) * 32'h0000_9E37);
  endfunction

  // memory seen by the responder (updated from the design's writes)
  logic [DW-1:0] mem_store [int];
  // reference model state
  logic [DW-1:0] ref_mem [int];
  logic [5:0]    rtag [16];
  logic [3:0]    rv [16];
  logic [3:0]    rd [16];
  logic [DW-1:0] rdat [64];
  logic [AW+DW-1:0] exp_wr [$];
  logic [AW-1:0]    exp_rd [$];

  // memory responder
  int cyc = 0;
  bit rd_pend = 0;
  int rd_wait = 0;
  logic [AW-1:0] rd_addr = '0;

  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    mem_req_ready = (cyc % 3) != 1;
    mem_rsp_valid = 1'b0;
    if (rd_pend) begin
      if (rd_wait == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = mem_store.exists(int'(rd_addr)) ? mem_store[int'(rd_addr)] : dflt(rd_addr);
        rd_pend = 0;
      end else rd_wait--;
    end
  end

  // per-clock monitor against the reference expectations
  initial forever begin
    @(negedge clk);
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        if (exp_wr.size() == 0) begin
          chk(0, "R6", "unexpected write-back addr", longint'(mem_req_addr), 0);
        end else begin
          logic [AW+DW-1:0] e;
          e = exp_wr.pop_front();
          chk(mem_req_addr == e[AW+DW-1:DW], "R6", "write-back address",
              longint'(mem_req_addr), longint'(e[AW+DW-1:DW]));
          chk(mem_req_wdata == e[DW-1:0], "R9", "write-back data",
              longint'(mem_req_wdata), longint'(e[DW-1:0]));
        end
        mem_store[int'(mem_req_addr)] = mem_req_wdata;
      end else begin
        if (exp_rd.size() == 0) begin
          chk(0, "R3", "unexpected sector read addr", longint'(mem_req_addr), 0);
        end else begin
          logic [AW-1:0] e;
          e = exp_rd.pop_front();
          chk(mem_req_addr == e, "R5", "fill address", longint'(mem_req_addr), longint'(e));
        end
        rd_pend = 1;
        rd_wait = 2;
        rd_addr = mem_req_addr;
      end
    end
  end

  task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [5:0] tg;
    logic [3:0] ix;
    logic [1:0] sc;
    bit miss;
    logic [DW-1:0] expv;
    int stalls;
    tg = a[11:6]; ix = a[5:2]; sc = a[1:0];
    miss = 0;
    expv = '0;
    if (rtag[ix] != tg) begin
      miss = 1;
      for (int s = 0; s < 4; s++) begin
        if (rd[ix][s]) begin
          logic [AW-1:0] wa;
          wa = {rtag[ix], ix, 2'(s)};
          exp_wr.push_back({wa, rdat[{ix, 2'(s)}]});
          ref_mem[int'(wa)] = rdat[{ix, 2'(s)}];
        end
      end
      rv[ix] = '0; rd[ix] = '0; rtag[ix] = tg;
    end
    if (!wr && !rv[ix][sc]) begin
      miss = 1;
      exp_rd.push_back(a);
      rdat[{ix, sc}] = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a);
      rv[ix][sc] = 1'b1; rd[ix][sc] = 1'b0;
    end
    if (wr) begin
      rdat[{ix, sc}] = d; rv[ix][sc] = 1'b1; rd[ix][sc] = 1'b1;
    end else expv = rdat[{ix, sc}];

    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    stalls = 0;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      stalls++;
      if (stalls > 500) break;
    end
    if (miss) chk(stalls > 0, "R7", "stall cycles on miss", stalls, 1);
    else chk(stalls == 0, wr ? "R2" : "R4", "stall cycles on hit", stalls, 0);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    @(negedge clk);
    if (wr) chk(rsp_valid == 1'b0, "R4", "rsp_valid after store", rsp_valid, 0);
    else begin
      chk(rsp_valid == 1'b1, "R4", "rsp_valid after load", rsp_valid, 1);
      chk(rsp_rdata == expv, "R4", "load data", rsp_rdata, expv);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic drained(input string rq);
    chk(exp_wr.size() == 0, rq, "pending write-backs", exp_wr.size(), 0);
    chk(exp_rd.size() == 0, rq, "pending fills", exp_rd.size(), 0);
  endtask

  initial begin
    repeat (2000 * 60) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 16; i++) begin rtag[i] = '0; rv[i] = '0; rd[i] = '0; end
    for (int i = 0; i < 64; i++) rdat[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(req_ready == 1'b0, "R1", "req_ready after reset", req_ready, 0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", mem_req_valid, 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    @(posedge clk);
    #1;

    // R1 R5: tag 0 matches the reset tag but the sector is empty -> fill
    cpu_op(0, 12'h000, '0);
    drained("R1");
    cpu_op(0, 12'h000, '0);          // R4 hit
    // R2 R3: store into an empty sector, no fetch
    cpu_op(1, 12'h002, 32'hAAAA_0002);
    drained("R2");
    cpu_op(0, 12'h002, '0);          // R3 hit on the stored sector
    cpu_op(0, 12'h003, '0);          // R3 single-sector fill
    // R9: merged stores
    cpu_op(1, 12'h001, 32'hBBBB_0001);
    cpu_op(1, 12'h001, 32'hCCCC_0001);
    drained("R9");
    // R6: evict sectors 1 and 2 (dirty) only, in order, then fill
    cpu_op(0, 12'h040, '0);
    drained("R6");
    // R6 R9: clean line evicted, merged value reloaded from memory
    cpu_op(0, 12'h001, '0);
    drained("R6");
    // R6: full dirty line on line 5, evicted by a store
    for (int s = 0; s < 4; s++) cpu_op(1, {6'd2, 4'd5, 2'(s)}, 32'h5500_0000 + s);
    cpu_op(1, {6'd3, 4'd5, 2'd2}, 32'h7777_7777);
    drained("R6");

    // mixed pseudo-random traffic on 4 tags x 4 lines
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cpu_op(lfsr[0], {4'd0, lfsr[5:4], 2'b00, lfsr[3:2], lfsr[7:6]},
             {lfsr, lfsr ^ 16'h5A5A});
    end
    drained("R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule